// File: doc/BRIEF.md
# Serial Read CRC-8 Appender

This block turns the bytes of a read response into a one-bit serial stream and, for read instructions that ask for it, follows the data with a checksum byte. Bytes arrive over a valid/ready handshake together with a last-byte flag and the 2-bit opcode of the current instruction. The downstream side moves one bit out per pulse of a bit strobe and sees the current bit on `ser_bit` while `ser_busy` is high.

The checksum is an 8-bit CRC built on x^8 + x^5 + x^4 + 1. It is computed in reflected (shift-right) form. Each data bit enters the CRC register in the same cycle that the strobe moves it off the serial output. A transaction starts with the first byte accepted after reset or after a byte marked last. That first byte clears the CRC register and fixes whether the CRC is on. When the CRC is on, the CRC byte follows the last data byte at once. When it is off, the stream ends after the last data byte.

Top module: `crc_read_serializer`

## Requirements
- R1: After reset, `ser_busy` is 0 and `in_ready` is 1.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from the edge after acceptance until the last bit of that byte, or of the CRC byte that follows it, has been strobed out. A byte offered while `in_ready` is 0 is not taken and does not change the output.
- R3: Every byte is sent least significant bit first. `ser_bit` shows the current bit, and each `bit_strobe` pulse while `ser_busy` is 1 moves to the next bit. Between strobes, `ser_bit` and `ser_busy` hold their values.
- R4: The CRC is on for a transaction only when `in_opcode` equals binary 10 on the transaction's first byte. The opcode on later bytes of the same transaction is ignored.
- R5: For each data bit d, the CRC register c is updated in reflected form. Take fb = c[0] ^ d and shift c right by one. If fb is 1, XOR c with 8'h8C.
- R6: The CRC register is cleared to 8'h00 when the first byte of a transaction is accepted.
- R7: When the CRC is on, the CRC byte (the register value after the last data bit) is sent LSB first right after the last data bit, with no idle cycle between them. `in_ready` stays 0 until the CRC byte has been sent.
- R8: When the CRC is off, no extra byte is sent. `ser_busy` falls after the last data bit.
- R9: The CRC byte over the ASCII string "123456789" is 8'hA1. The CRC byte over the single byte 8'h00 is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A response byte is offered |
| in_ready | output | 1 | The block can take a byte |
| in_data | input | 8 | Response byte |
| in_last | input | 1 | This byte ends the transaction |
| in_opcode | input | 2 | Instruction opcode; binary 10 turns the CRC on |
| bit_strobe | input | 1 | Moves one bit off the serial output |
| ser_bit | output | 1 | Current serial bit |
| ser_busy | output | 1 | `ser_bit` holds a valid bit |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 2-bit opcode, the binary 10 CRC opcode and the reflected polynomial 8'h8C. These defaults bring the two known CRC values within reach. They also let the bench run a string test that toggles opcodes between 10 and other codes, both at the first byte and in the middle of a transaction. The strobe is driven on every cycle, every third cycle and in an irregular pattern. This checks that the CRC byte follows the data with no gap at every strobe rate. Bytes are also offered while the block is busy.

// File: rtl/crc_ser_pkg.sv
// Package: constants shared by the CRC read serializer modules.
// Assumes: bytes are 8 bits; the reflected polynomial constant matches x^8+x^5+x^4+1.
package crc_ser_pkg;
    localparam int          BYTE_W       = 8;
    localparam int          OPC_W        = 2;
    localparam logic [1:0]  CRC_OPCODE   = 2'b10;
    localparam logic [7:0]  POLY_REFLECT = 8'h8C;
endpackage

// File: rtl/crc_bit_lfsr.sv
// Module: bit-serial reflected CRC register.
// Does: holds the CRC and advances it by one data bit when step is high.
// Assumes: clr and step are never both needed in one cycle (clr wins).
module crc_bit_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h8C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] crc_nxt
);
    logic fb;

    // Next value of the register after absorbing din (shift-right form).
    always_comb begin
        fb      = crc_q[0] ^ din;
        crc_nxt = (crc_q >> 1) ^ (fb ? POLY : '0);
    end

    // CRC state register: cleared on reset or clr, advanced on step.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= '0;
        else if (clr)    crc_q <= '0;
        else if (step)   crc_q <= crc_nxt;
    end

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(crc_q));
endmodule

// File: rtl/lsb_shifter.sv
// Module: byte-to-bit shifter, least significant bit first.
// Does: loads a word, presents bit 0, moves one bit per strobe, drops busy after W bits.
// Assumes: load is only raised while idle or on the strobe of the final bit.
module lsb_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         strobe,
    output logic         bit_o,
    output logic         busy_o,
    output logic         done_o
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    // Final bit of the word is being strobed out this cycle.
    always_comb done_o = busy_o && strobe && (cnt_q == CW'(W - 1));

    assign bit_o = sh_q[0];

    // Shift register, bit counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            busy_o <= 1'b0;
        end else if (load) begin
            sh_q   <= load_val;
            cnt_q  <= '0;
            busy_o <= 1'b1;
        end else if (busy_o && strobe) begin
            sh_q   <= sh_q >> 1;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CW'(W - 1)) busy_o <= 1'b0;
        end
    end

    assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !strobe && !load) |=> (busy_o && $stable(bit_o)));
endmodule

// File: rtl/crc_read_serializer.sv
// Module: top of the read serializer with optional trailing CRC byte.
// Does: accepts response bytes, shifts them out LSB first, and for opcode 10
//       transactions appends the CRC of the sent bits as one more byte.
// Assumes: the downstream strobe is a single-cycle pulse per bit.
module crc_read_serializer
    import crc_ser_pkg::*;
#(
    parameter int               DW      = BYTE_W,
    parameter int               OW      = OPC_W,
    parameter logic [OW-1:0]    CRC_OPC = CRC_OPCODE,
    parameter logic [DW-1:0]    POLY    = POLY_REFLECT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    input  logic [OW-1:0] in_opcode,
    input  logic          bit_strobe,
    output logic          ser_bit,
    output logic          ser_busy
);
    logic          first_q;
    logic          crc_en_q;
    logic          last_q;
    logic          crc_phase_q;
    logic          accept;
    logic          append;
    logic          shift_done;
    logic          crc_step;
    logic          crc_clr;
    logic          sh_load;
    logic [DW-1:0] sh_val;
    logic [DW-1:0] crc_q;
    logic [DW-1:0] crc_nxt;

    // Handshake, CRC control and shifter load selection.
    always_comb begin
        in_ready = !ser_busy;
        accept   = in_valid && in_ready;
        crc_clr  = accept && first_q;
        crc_step = ser_busy && bit_strobe && !crc_phase_q && crc_en_q;
        append   = shift_done && !crc_phase_q && last_q && crc_en_q;
        sh_load  = accept || append;
        sh_val   = accept ? in_data : crc_nxt;
    end

    // Transaction framing: first-byte flag, CRC enable, last flag, CRC phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q     <= 1'b1;
            crc_en_q    <= 1'b0;
            last_q      <= 1'b0;
            crc_phase_q <= 1'b0;
        end else if (accept) begin
            first_q     <= in_last;
            last_q      <= in_last;
            crc_phase_q <= 1'b0;
            if (first_q) crc_en_q <= (in_opcode == CRC_OPC);
        end else if (append) begin
            crc_phase_q <= 1'b1;
        end
    end

    crc_bit_lfsr #(.W(DW), .POLY(POLY)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (crc_clr),
        .step    (crc_step),
        .din     (ser_bit),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    lsb_shifter #(.W(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .strobe   (bit_strobe),
        .bit_o    (ser_bit),
        .busy_o   (ser_busy),
        .done_o   (shift_done)
    );

    assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ser_busy && !in_ready));
    assert_clear_on_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && first_q) |=> (crc_q == '0));
    assert_crc_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        append |=> (ser_busy && crc_phase_q));
    assert_crc_only_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_busy && crc_phase_q) |-> crc_en_q);
endmodule

// File: tb/crc_read_serializer_test.sv
// Bench: behavioural bit-queue model compared on every clock, plus known CRC values.
module crc_read_serializer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic [1:0] in_opcode = '0;
    logic       bit_strobe = 1'b0;
    logic       ser_bit;
    logic       ser_busy;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int strobe_mode = 0;
    bit done_flag = 1'b0;

    bit     mq[$];     // expected bits still to appear on ser_bit
    bit     cap[$];    // bits actually strobed out
    bit     m_first = 1'b1;
    bit     m_en = 1'b0;
    logic [7:0] m_crc = '0;

    crc_read_serializer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_opcode(in_opcode),
        .bit_strobe(bit_strobe), .ser_bit(ser_bit), .ser_busy(ser_busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            bit fb;
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: advances on each edge from inputs held since the last falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_first = 1'b1;
            m_en    = 1'b0;
            m_crc   = '0;
        end else if (mq.size() > 0) begin
            if (bit_strobe) mq.pop_front();
        end else if (in_valid) begin
            if (m_first) begin
                m_crc = '0;
                m_en  = (in_opcode == 2'b10);
            end
            for (int i = 0; i < 8; i++) mq.push_back(in_data[i]);
            m_crc   = crc_byte(m_crc, in_data);
            m_first = in_last;
            if (in_last && m_en)
                for (int i = 0; i < 8; i++) mq.push_back(m_crc[i]);
        end
    end

    // Capture of bits the design actually moved out.
    always @(posedge clk) begin
        if (rst_n && ser_busy && bit_strobe) cap.push_back(ser_bit);
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check(ser_busy == (mq.size() > 0), "R7 R8 busy", ser_busy, mq.size() > 0);
            check(in_ready == (mq.size() == 0), "R2 ready", in_ready, mq.size() == 0);
            if (mq.size() > 0 && ser_busy)
                check(ser_bit == mq[0], "R3 R5 serial bit", ser_bit, mq[0]);
        end
    end

    // Strobe pattern generator and cycle counter / watchdog.
    always @(negedge clk) begin
        cyc++;
        case (strobe_mode)
            0:       bit_strobe = 1'b1;
            1:       bit_strobe = (cyc % 3 == 0);
            default: bit_strobe = (((cyc * 7) % 5) < 2);
        endcase
        if (cyc > WATCHDOG && !done_flag) begin
            check(1'b0, "watchdog", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic finish_run();
        done_flag = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit last, input logic [1:0] op);
        do @(negedge clk); while (!in_ready);
        in_valid  = 1'b1;
        in_data   = d;
        in_last   = last;
        in_opcode = op;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (ser_busy);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] tail_byte();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = cap[cap.size() - 8 + i];
        return r;
    endfunction

    task automatic send_string(input logic [1:0] op_first, input logic [1:0] op_rest);
        string s;
        s = "123456789";
        for (int i = 0; i < 9; i++)
            send_byte(s[i], i == 8, (i == 0) ? op_first : op_rest);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ser_busy == 1'b0, "R1 busy in reset", ser_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ser_busy == 1'b0 && in_ready == 1'b1, "R1 idle after reset", {ser_busy, in_ready}, 1);

        // R9 / R7: known CRC over the check string, strobe every cycle.
        strobe_mode = 0;
        cap.delete();
        send_string(2'b10, 2'b10);
        check(cap.size() == 80, "R7 bit count with CRC", cap.size(), 80);
        check(tail_byte() == 8'hA1, "R9 check string CRC", tail_byte(), 8'hA1);

        // R9 / R6: single zero byte gives zero CRC after a fresh clear.
        cap.delete();
        send_byte(8'h00, 1'b1, 2'b10);
        wait_idle();
        check(cap.size() == 16, "R7 single byte count", cap.size(), 16);
        check(tail_byte() == 8'h00, "R9 R6 zero byte CRC", tail_byte(), 8'h00);

        // R8: opcode 01 sends only data bits; R3 LSB first on first byte.
        strobe_mode = 1;
        cap.delete();
        send_string(2'b01, 2'b01);
        check(cap.size() == 72, "R8 no CRC byte", cap.size(), 72);
        check({cap[7], cap[6], cap[5], cap[4], cap[3], cap[2], cap[1], cap[0]} == 8'h31,
              "R3 LSB first", {cap[7], cap[6], cap[5], cap[4], cap[3], cap[2], cap[1], cap[0]}, 8'h31);

        // R4: opcode on later bytes ignored, both ways.
        strobe_mode = 2;
        cap.delete();
        send_string(2'b10, 2'b00);
        check(cap.size() == 80, "R4 later opcode ignored (on)", cap.size(), 80);
        check(tail_byte() == 8'hA1, "R4 R6 CRC repeats", tail_byte(), 8'hA1);
        cap.delete();
        send_string(2'b11, 2'b10);
        check(cap.size() == 72, "R4 later opcode ignored (off)", cap.size(), 72);

        // R2: bytes offered while busy are not taken.
        strobe_mode = 1;
        cap.delete();
        send_byte(8'hC3, 1'b0, 2'b10);
        for (int k = 0; k < 5; k++) begin
            in_valid = 1'b1;
            in_data  = 8'hFF;
            in_last  = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        send_byte(8'h5A, 1'b1, 2'b10);
        wait_idle();
        check(cap.size() == 24, "R2 busy offers ignored", cap.size(), 24);
        check(tail_byte() == crc_byte(crc_byte(8'h00, 8'hC3), 8'h5A), "R5 two-byte CRC",
              tail_byte(), crc_byte(crc_byte(8'h00, 8'hC3), 8'h5A));

        // Back-to-back transactions with irregular strobes.
        strobe_mode = 2;
        for (int t = 0; t < 4; t++) begin
            for (int b = 0; b < 3; b++)
                send_byte(8'(t * 37 + b * 11), b == 2, (t % 2 == 0) ? 2'b10 : 2'b00);
        end
        wait_idle();

        finish_run();
    end
endmodule